// File: doc/BRIEF.md
# Configurable Trigger Interrupt Controller

This block gathers 32 interrupt source lines and turns them into two processor request outputs, a normal request (`irq_o`) and a fast request (`fiq_o`). Each source is brought into the clock domain through a two-stage synchronizer. It is then qualified by two per-line settings: a detection style (level or edge) and a polarity. The polarity selects active-high or active-low for level lines, and rising or falling for edge lines. An edge event is held in a sticky flag until software clears it by writing ones to the acknowledge word.

The qualified status is gated by a per-line mask, and each enabled line is steered to one of the two outputs by a per-line route bit. Software finds the line to service through a read-only word. That word holds the index of the lowest-numbered pending line that is steered to the normal output, with bit 31 set when no such line is pending.

Configuration and status are reached over a plain 32-bit register port. The port has separate write and read strobes and a byte offset. Read data is registered and holds between reads.

Top module: `trig_intc`

## Requirements
- R1: After reset the mask word reads 0xFFFFFFFF, the mode, polarity and route words read 0, the next-line word reads 0x80000000, and both request outputs are low.
- R2: A line in level mode (mode bit 0) with polarity bit 0 shows status 1 while its input is high and 0 while it is low. The input reaches status through a two-flop synchronizer, so a read strobed one cycle after the input changes still returns the old value.
- R3: A level-mode line with polarity bit 1 is active while its input is low.
- R4: A line in edge mode (mode bit 1) with polarity bit 0 sets its status on a rising input. The status stays set after the input falls again.
- R5: An edge-mode line with polarity bit 1 sets its status on a falling input and ignores a rising one.
- R6: Writing the acknowledge word at offset 0x08 clears each latched edge whose data bit is 1 and leaves the other latched edges set. A new edge seen in the same cycle as the clear keeps its flag set.
- R7: A line whose mask bit is 1 never drives either output and is not reported by the next-line word. Its raw state still shows in the status word at 0x00.
- R8: A pending unmasked line drives `fiq_o` when its route bit (offset 0x14) is 1 and `irq_o` when it is 0. Both outputs are registered.
- R9: The next-line word at 0x18 returns, in bits [4:0], the index of the lowest pending unmasked line whose route bit is 0. When there is no such line it returns 0x80000000.
- R10: The offsets are status 0x00, mask 0x04, acknowledge 0x08, mode 0x0C, polarity 0x10, route 0x14 and next-line 0x18. A read of any other offset, misaligned ones included, returns 0, and writes to the status and next-line words have no effect.
- R11: Read data is registered. It changes in the cycle after a read strobe and holds its value while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Asynchronous interrupt source lines, line N on bit N |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Several properties are checked on every cycle. The outputs stay quiet while everything is masked, and latched edges never drop except through an acknowledge write. An acknowledge write clears the flags it targets, the next-line word always names the lowest steered pending line, unmapped reads return zero, and read data holds between strobes. Other behaviours only show up in the bench's scenarios: the polarity choices, the two-stage synchronizer latency, the sticky nature of an edge after its input returns, and the split of lines between the two outputs. The bench drives the source pins and compares the register reads and request outputs against values worked out from the requirements.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes and register offsets for the trigger interrupt controller.
// Assumes a 32-bit data path and byte offsets on a 5-bit address.
package intc_pkg;
    localparam int NSRC = 32;
    localparam int DW   = 32;
    localparam int AW   = 5;

    typedef enum logic [AW-1:0] {
        OFS_STAT  = 5'h00,
        OFS_MASK  = 5'h04,
        OFS_ACK   = 5'h08,
        OFS_MODE  = 5'h0C,
        OFS_POL   = 5'h10,
        OFS_ROUTE = 5'h14,
        OFS_NEXT  = 5'h18
    } reg_ofs_e;

    localparam logic [DW-1:0] NONE_PENDING = 32'h8000_0000;
endpackage

// File: rtl/intc_sync.sv
`timescale 1ns/1ps
// Module: two-flop synchronizer with an extra history stage.
// Produces the current synchronized sample and the one before it for edge detection.
// Assumes the inputs are asynchronous level signals.
module intc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] prev_q;

    // Shift the raw inputs through two stages, then keep one sample of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= d_i;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/intc_detect.sv
`timescale 1ns/1ps
// Module: per-line trigger qualification and sticky edge flags.
// A level line reports its polarity-corrected sample directly. An edge line
// reports a flag set by the chosen transition and cleared by an acknowledge bit.
// Set wins over clear in the same cycle. Assumes synchronized inputs.
module intc_detect #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cur_i,
    input  logic [N-1:0] prev_i,
    input  logic [N-1:0] mode_i,
    input  logic [N-1:0] pol_i,
    input  logic         ack_en_i,
    input  logic [N-1:0] ack_bits_i,
    output logic [N-1:0] evt_o,
    output logic [N-1:0] edge_o,
    output logic [N-1:0] raw_o
);
    logic [N-1:0] edge_q;

    for (genvar g = 0; g < N; g++) begin : g_line
        logic rise_w;
        logic fall_w;
        assign rise_w   = cur_i[g] & ~prev_i[g];
        assign fall_w   = ~cur_i[g] & prev_i[g];
        assign evt_o[g] = mode_i[g] & (pol_i[g] ? fall_w : rise_w);

        // Hold an edge event until acknowledged; a fresh event beats the clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                edge_q[g] <= 1'b0;
            end else if (evt_o[g]) begin
                edge_q[g] <= 1'b1;
            end else if (ack_en_i && ack_bits_i[g]) begin
                edge_q[g] <= 1'b0;
            end
        end

        assign raw_o[g] = mode_i[g] ? edge_q[g] : (cur_i[g] ^ pol_i[g]);
    end

    assign edge_o = edge_q;
endmodule

// File: rtl/intc_prio.sv
`timescale 1ns/1ps
// Module: lowest-index-first encoder for the next-line word.
// Returns the index of the lowest set bit, or the none-pending code when empty.
module intc_prio #(
    parameter int N = 32
) (
    input  logic [N-1:0]           vec_i,
    output logic [intc_pkg::DW-1:0] word_o
);
    // Scan from the top so the lowest set bit is the last one written.
    always_comb begin
        word_o = intc_pkg::NONE_PENDING;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) word_o = intc_pkg::DW'(i);
        end
    end
endmodule

// File: rtl/intc_regs.sv
`timescale 1ns/1ps
// Module: configuration registers, acknowledge decode and registered read port.
// Assumes single-cycle strobes; unmapped or misaligned reads return zero.
module intc_regs
    import intc_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [N-1:0]  raw_i,
    input  logic [DW-1:0] next_i,
    output logic [N-1:0]  mask_o,
    output logic [N-1:0]  mode_o,
    output logic [N-1:0]  pol_o,
    output logic [N-1:0]  route_o,
    output logic          ack_en_o,
    output logic [N-1:0]  ack_bits_o,
    output logic [DW-1:0] rdata_o
);
    logic [N-1:0]  mask_q, mode_q, pol_q, route_q;
    logic [DW-1:0] rdata_q;
    logic [DW-1:0] rmux_w;

    // Capture writes to the four writable configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '1;
            mode_q  <= '0;
            pol_q   <= '0;
            route_q <= '0;
        end else if (wr_i) begin
            case (addr_i)
                OFS_MASK:  mask_q  <= wdata_i[N-1:0];
                OFS_MODE:  mode_q  <= wdata_i[N-1:0];
                OFS_POL:   pol_q   <= wdata_i[N-1:0];
                OFS_ROUTE: route_q <= wdata_i[N-1:0];
                default:   ;
            endcase
        end
    end

    // Acknowledge is a pulse carrying the write data as a clear vector.
    assign ack_en_o   = wr_i && (addr_i == OFS_ACK);
    assign ack_bits_o = wdata_i[N-1:0];

    // Select the read word for the current offset.
    always_comb begin
        rmux_w = '0;
        case (addr_i)
            OFS_STAT:  rmux_w[N-1:0] = raw_i;
            OFS_MASK:  rmux_w[N-1:0] = mask_q;
            OFS_MODE:  rmux_w[N-1:0] = mode_q;
            OFS_POL:   rmux_w[N-1:0] = pol_q;
            OFS_ROUTE: rmux_w[N-1:0] = route_q;
            OFS_NEXT:  rmux_w        = next_i;
            default:   rmux_w        = '0;
        endcase
    end

    // Register read data on a strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_i) begin
            rdata_q <= rmux_w;
        end
    end

    assign mask_o  = mask_q;
    assign mode_o  = mode_q;
    assign pol_o   = pol_q;
    assign route_o = route_q;
    assign rdata_o = rdata_q;
endmodule

// File: rtl/trig_intc.sv
`timescale 1ns/1ps
// Module: top of the configurable trigger interrupt controller.
// Synchronizes the sources, qualifies them, masks them and steers each to the
// normal or fast request. Both requests are registered.
module trig_intc
    import intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_i,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             irq_o,
    output logic             fiq_o
);
    logic [NSRC-1:0] cur_w, prev_w;
    logic [NSRC-1:0] mask_w, mode_w, pol_w, route_w;
    logic            ack_en_w;
    logic [NSRC-1:0] ack_bits_w;
    logic [NSRC-1:0] evt_w, edge_w, raw_w;
    logic [NSRC-1:0] pend_w, irq_vec_w, fiq_vec_w;
    logic [DW-1:0]   next_w;
    logic            irq_q, fiq_q;

    intc_sync #(.W(NSRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(src_i), .cur_o(cur_w), .prev_o(prev_w)
    );

    intc_detect #(.N(NSRC)) u_det (
        .clk(clk), .rst_n(rst_n), .cur_i(cur_w), .prev_i(prev_w),
        .mode_i(mode_w), .pol_i(pol_w), .ack_en_i(ack_en_w),
        .ack_bits_i(ack_bits_w), .evt_o(evt_w), .edge_o(edge_w), .raw_o(raw_w)
    );

    assign pend_w    = raw_w & ~mask_w;
    assign irq_vec_w = pend_w & ~route_w;
    assign fiq_vec_w = pend_w & route_w;

    intc_prio #(.N(NSRC)) u_prio (
        .vec_i(irq_vec_w), .word_o(next_w)
    );

    intc_regs #(.N(NSRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .rd_i(bus_rd),
        .addr_i(bus_addr), .wdata_i(bus_wdata), .raw_i(raw_w), .next_i(next_w),
        .mask_o(mask_w), .mode_o(mode_w), .pol_o(pol_w), .route_o(route_w),
        .ack_en_o(ack_en_w), .ack_bits_o(ack_bits_w), .rdata_o(bus_rdata)
    );

    // Register the two request outputs from the steered pending vectors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            fiq_q <= 1'b0;
        end else begin
            irq_q <= |irq_vec_w;
            fiq_q <= |fiq_vec_w;
        end
    end

    assign irq_o = irq_q;
    assign fiq_o = fiq_q;
endmodule

// File: rtl/trig_intc_chk.sv
`timescale 1ns/1ps
// Module: assertion checker bound into trig_intc.
module trig_intc_chk
    import intc_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic            bus_rd,
    input logic [AW-1:0]   bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic [DW-1:0]   bus_rdata,
    input logic            irq_o,
    input logic            fiq_o,
    input logic [NSRC-1:0] mask_w,
    input logic [NSRC-1:0] route_w,
    input logic [NSRC-1:0] evt_w,
    input logic [NSRC-1:0] edge_w,
    input logic [NSRC-1:0] irq_vec_w,
    input logic [DW-1:0]   next_w
);
    logic mapped_w;
    assign mapped_w = (bus_addr[1:0] == 2'b00) && (bus_addr <= OFS_NEXT);

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_o && !fiq_o));

    p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFS_ACK) |=> ((edge_w & $past(edge_w)) == $past(edge_w)));

    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_ACK && evt_w == '0) |=> ((edge_w & $past(bus_wdata)) == '0));

    p_all_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_w == '1) |=> (!irq_o && !fiq_o));

    p_fiq_needs_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> $past(route_w != '0));

    p_irq_needs_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(route_w != '1));

    p_next_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !next_w[31] |-> (irq_vec_w[next_w[4:0]] &&
            ((irq_vec_w & ((32'd1 << next_w[4:0]) - 32'd1)) == '0)));

    p_next_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        next_w[31] |-> (irq_vec_w == '0));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !mapped_w) |=> (bus_rdata == '0));

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind trig_intc trig_intc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o), .mask_w(mask_w), .route_w(route_w),
    .evt_w(evt_w), .edge_w(edge_w), .irq_vec_w(irq_vec_w), .next_w(next_w)
);

// File: tb/sim_trig_intc.sv
`timescale 1ns/1ps
module sim_trig_intc;
    localparam logic [4:0] A_STAT = 5'h00, A_MASK = 5'h04, A_ACK = 5'h08,
                           A_MODE = 5'h0C, A_POL = 5'h10, A_ROUTE = 5'h14,
                           A_NEXT = 5'h18;
    localparam logic [31:0] NONE = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #5 clk = ~clk;

    trig_intc u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each registered read result against the scoreboard.
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: actual=%h expected=<none>", bus_rdata);
            end else begin
                chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    // Driver: push the expected value, then strobe the read.
    task automatic rd_exp(input logic [4:0] a, input logic [31:0] e, input string tag);
        @(negedge clk); exp_q.push_back(e); tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic set_src(input int n, input logic v);
        @(negedge clk); src_i[n] = v;
        settle();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk({31'b0, irq_o}, 0, "R1 irq after reset");
        chk({31'b0, fiq_o}, 0, "R1 fiq after reset");
        rd_exp(A_MASK, 32'hFFFF_FFFF, "R1 mask reset");
        rd_exp(A_MODE, 0, "R1 mode reset");
        rd_exp(A_POL, 0, "R1 polarity reset");
        rd_exp(A_ROUTE, 0, "R1 route reset");
        rd_exp(A_NEXT, NONE, "R1 next reset");
        rd_exp(A_STAT, 0, "R1 status reset");
        // R10 map, unmapped and read-only words
        wr(A_MODE, 32'h0000_00F0);
        rd_exp(A_MODE, 32'h0000_00F0, "R10 mode readback");
        wr(A_STAT, 32'h0000_1234);
        rd_exp(A_STAT, 0, "R10 status not writable");
        rd_exp(5'h1C, 0, "R10 unmapped read");
        rd_exp(5'h02, 0, "R10 misaligned read");
        wr(A_NEXT, 32'h5);
        rd_exp(A_NEXT, NONE, "R10 next not writable");
        // lines 2,3 edge; line 1 active-low, line 3 falling
        wr(A_MODE, 32'h0000_000C);
        wr(A_POL, 32'h0000_000A);
        rd_exp(A_POL, 32'h0000_000A, "R10 polarity readback");
        settle();
        rd_exp(A_STAT, 32'h2, "R3 active-low line seen while masked");
        chk({31'b0, irq_o}, 0, "R7 masked line no irq");
        wr(A_MASK, 0);
        settle();
        chk({31'b0, irq_o}, 1, "R3 active-low line raises irq");
        rd_exp(A_NEXT, 1, "R9 next is line 1");
        set_src(1, 1'b1);
        rd_exp(A_STAT, 0, "R3 active-low line idle when high");
        chk({31'b0, irq_o}, 0, "R3 irq drops");
        // R2 synchronizer latency on level line 7
        @(negedge clk); src_i[7] = 1'b1;
        rd_exp(A_STAT, 0, "R2 old value one cycle after change");
        rd_exp(A_STAT, 32'h80, "R2 level line high");
        set_src(7, 1'b0);
        rd_exp(A_STAT, 0, "R2 level line follows low");
        // R4 rising edge on line 2 is sticky
        set_src(2, 1'b1);
        rd_exp(A_STAT, 32'h4, "R4 rising edge latched");
        rd_exp(A_NEXT, 2, "R9 next is line 2");
        set_src(2, 1'b0);
        rd_exp(A_STAT, 32'h4, "R4 edge stays after input falls");
        chk({31'b0, irq_o}, 1, "R4 irq held by edge");
        wr(A_ACK, 32'h4);
        settle();
        rd_exp(A_STAT, 0, "R6 acknowledge clears line 2");
        chk({31'b0, irq_o}, 0, "R6 irq drops after acknowledge");
        // R5 falling edge on line 3
        set_src(3, 1'b1);
        rd_exp(A_STAT, 0, "R5 rising ignored on falling line");
        set_src(3, 1'b0);
        rd_exp(A_STAT, 32'h8, "R5 falling edge latched");
        wr(A_ACK, 0);
        rd_exp(A_STAT, 32'h8, "R6 zero bits do not clear");
        wr(A_ACK, 32'hFFFF_FFFF);
        rd_exp(A_STAT, 0, "R6 clear all");
        // R8 routing
        wr(A_ROUTE, 32'h1);
        set_src(0, 1'b1);
        chk({31'b0, fiq_o}, 1, "R8 fiq from routed line 0");
        chk({31'b0, irq_o}, 0, "R8 no irq from routed line");
        rd_exp(A_NEXT, NONE, "R9 fiq line excluded from next");
        set_src(5, 1'b1);
        chk({31'b0, irq_o}, 1, "R8 irq from line 5");
        rd_exp(A_NEXT, 5, "R9 next is line 5");
        @(negedge clk); src_i[0] = 1'b0; src_i[5] = 1'b0;
        settle();
        chk({30'b0, fiq_o, irq_o}, 0, "R8 both requests low");
        // R7 masking
        @(negedge clk); src_i[5] = 1'b1;
        wr(A_MASK, 32'h20);
        settle();
        rd_exp(A_STAT, 32'h20, "R7 status shows masked line");
        chk({31'b0, irq_o}, 0, "R7 masked line no irq");
        rd_exp(A_NEXT, NONE, "R7 masked line not next");
        wr(A_MASK, 0);
        settle();
        chk({31'b0, irq_o}, 1, "R7 unmask raises irq");
        set_src(5, 1'b0);
        // R9 priority
        @(negedge clk); src_i[9] = 1'b1; src_i[6] = 1'b1;
        settle();
        rd_exp(A_NEXT, 6, "R9 lowest of 6 and 9");
        wr(A_MASK, 32'h40);
        rd_exp(A_NEXT, 9, "R9 next after masking 6");
        wr(A_MASK, 0);
        @(negedge clk); src_i[9] = 1'b0; src_i[6] = 1'b0;
        settle();
        rd_exp(A_NEXT, NONE, "R9 none pending");
        // R11 registered read timing and hold
        @(negedge clk); exp_q.push_back(0); tag_q.push_back("R11 mask read");
        bus_rd = 1'b1; bus_addr = A_MASK;
        @(negedge clk); exp_q.push_back(32'hA); tag_q.push_back("R11 polarity read");
        bus_addr = A_POL;
        #4 chk(bus_rdata, 0, "R11 data unchanged before edge");
        @(negedge clk); bus_rd = 1'b0;
        repeat (3) @(negedge clk);
        chk(bus_rdata, 32'hA, "R11 data held without strobe");
        repeat (2) @(negedge clk);
        chk(exp_q.size(), 0, "scoreboard drained");
        summary();
        $finish;
    end
endmodule